// File: doc/BRIEF.md
# Condition Evaluator with Conditional Move

This block turns a 4-bit condition code and the processor status flags (zero, sign, overflow, carry, plus a saturation flag) into one "condition met" decision. That decision is the one shared by conditional branches, set-on-condition and conditional move. The lower three bits of the code pick a flag test. The upper bit asks for the opposite sense of that test. Two codes break this pattern: one code is always true, and its inverted partner reports the saturation flag.

The same decision also drives a conditional-move datapath. The first operand comes from a register value, or, in the immediate form, from a sign-extended 5-bit immediate. When the condition holds, the first operand goes onto the destination bus; otherwise the second register operand does. A second 32-bit bus carries the set-on-condition value.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge. A synchronous active-high reset clears all outputs.

Top module: `cond_move_unit`

## Requirements
- R1: While reset is high at a rising edge, cond_met, move_result and setf_result become 0 at that edge.
- R2: Code 0x0 is met when flag_ov is 1; code 0x8 is met when flag_ov is 0.
- R3: Code 0x1 is met when flag_cy is 1 (unsigned lower); code 0x9 is met when flag_cy is 0.
- R4: Code 0x2 is met when flag_z is 1 (equal); code 0xA is met when flag_z is 0.
- R5: Code 0x4 is met when flag_s is 1 (negative); code 0xC is met when flag_s is 0.
- R6: Signed compares: 0x6 is met when (flag_s XOR flag_ov) is 1, 0xE when it is 0, 0x7 when ((flag_s XOR flag_ov) OR flag_z) is 1, 0xF when that expression is 0.
- R7: Unsigned compares: 0x3 (not higher) is met when (flag_cy OR flag_z) is 1, 0xB (higher) when it is 0.
- R8: Code 0x5 is always met regardless of flags; code 0xD is met exactly when flag_sat is 1.
- R9: move_result equals the first operand when the condition is met and reg_b otherwise; with use_imm = 0 the first operand is reg_a.
- R10: With use_imm = 1 the first operand is imm5 sign-extended to 32 bits (bit 4 copied into bits 31..5), and reg_a has no effect.
- R11: setf_result is 32'd1 when the condition is met and 32'd0 otherwise.
- R12: Every output shows the result for the inputs present at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_code | input | 4 | Condition code to evaluate |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_ov | input | 1 | Overflow flag |
| flag_cy | input | 1 | Carry flag |
| flag_sat | input | 1 | Saturation flag |
| use_imm | input | 1 | 1 selects the immediate as the first operand |
| imm5 | input | 5 | Signed 5-bit immediate |
| reg_a | input | 32 | First register operand |
| reg_b | input | 32 | Second register operand, used when the condition fails |
| cond_met | output | 1 | Registered condition decision |
| move_result | output | 32 | Registered conditional-move destination value |
| setf_result | output | 32 | Registered set-on-condition value |

## Verification
The hardest cases to reach are those that depend on flag combinations seldom seen together. The two-flag and three-flag compares must be tested where the flags disagree: overflow set with sign clear, and zero set together with a signed "greater" relation. The stimulus reaches these by sweeping every one of the 16 codes against all 32 flag combinations, so each compare sees every mix. The operand forms alternate during the sweep. The immediates 0x0F and 0x10 are driven on purpose to probe the sign-extension boundary.

// File: rtl/cond_move_pkg.sv
package cond_move_pkg;
  localparam int CODE_W = 4;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 5;

  typedef enum logic [2:0] {
    TST_OV   = 3'd0,
    TST_CY   = 3'd1,
    TST_Z    = 3'd2,
    TST_NH   = 3'd3,
    TST_S    = 3'd4,
    TST_ONE  = 3'd5,
    TST_LT   = 3'd6,
    TST_LE   = 3'd7
  } base_test_e;

  typedef struct packed {
    logic z;
    logic s;
    logic ov;
    logic cy;
    logic sat;
  } flags_t;
endpackage

// File: rtl/cond_decode.sv
module cond_decode
  import cond_move_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  flags_t            flags,
  output logic              met
);
  localparam int SEL_W = CODE_W - 1;

  base_test_e  sel;
  logic        base_true;
  logic        negate;
  logic        lt_sig;

  assign sel    = base_test_e'(code[SEL_W-1:0]);
  assign negate = code[CODE_W-1];
  assign lt_sig = flags.s ^ flags.ov;

  always_comb begin
    unique case (sel)
      TST_OV:  base_true = flags.ov;
      TST_CY:  base_true = flags.cy;
      TST_Z:   base_true = flags.z;
      TST_NH:  base_true = flags.cy | flags.z;
      TST_S:   base_true = flags.s;
      TST_ONE: base_true = 1'b1;
      TST_LT:  base_true = lt_sig;
      TST_LE:  base_true = lt_sig | flags.z;
      default: base_true = 1'b0;
    endcase
  end

  // The always-true slot does not invert: its upper-half partner reports saturation.
  always_comb begin
    if (sel == TST_ONE)
      met = negate ? flags.sat : 1'b1;
    else
      met = base_true ^ negate;
  end
endmodule

// File: rtl/move_select.sv
module move_select #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              take_a,
  output logic [DATA_W-1:0] result
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] first;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign first  = use_imm ? imm_ext : opnd_a;
  assign result = take_a ? first : opnd_b;
endmodule

// File: rtl/cond_move_unit.sv
module cond_move_unit
  import cond_move_pkg::*;
#(
  parameter int DATA_W = cond_move_pkg::DATA_W,
  parameter int IMM_W  = cond_move_pkg::IMM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cond_code,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_ov,
  input  logic              flag_cy,
  input  logic              flag_sat,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm5,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  output logic              cond_met,
  output logic [DATA_W-1:0] move_result,
  output logic [DATA_W-1:0] setf_result
);
  flags_t            flags;
  logic              met_c;
  logic [DATA_W-1:0] mv_c;

  assign flags = '{z: flag_z, s: flag_s, ov: flag_ov, cy: flag_cy, sat: flag_sat};

  cond_decode u_dec (
    .code  (cond_code),
    .flags (flags),
    .met   (met_c)
  );

  move_select #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .use_imm (use_imm),
    .imm     (imm5),
    .opnd_a  (reg_a),
    .opnd_b  (reg_b),
    .take_a  (met_c),
    .result  (mv_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_met    <= 1'b0;
      move_result <= '0;
      setf_result <= '0;
    end else begin
      cond_met    <= met_c;
      move_result <= mv_c;
      setf_result <= {{(DATA_W-1){1'b0}}, met_c};
    end
  end
endmodule

// File: rtl/cond_move_chk.sv
module cond_move_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cond_code,
  input logic              flag_z,
  input logic              flag_s,
  input logic              flag_ov,
  input logic              flag_cy,
  input logic              flag_sat,
  input logic              use_imm,
  input logic [IMM_W-1:0]  imm5,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b,
  input logic              cond_met,
  input logic [DATA_W-1:0] move_result,
  input logic [DATA_W-1:0] setf_result
);
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (cond_met == 1'b0 && move_result == '0 && setf_result == '0));

  a_r2_overflow_set: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(cond_code) == 4'h0) |-> (cond_met == $past(flag_ov)));

  a_r4_not_equal: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(cond_code) == 4'hA) |-> (cond_met == !$past(flag_z)));

  a_r8_always: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(cond_code) == 4'h5) |-> cond_met);

  a_r8_saturated: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(cond_code) == 4'hD) |-> (cond_met == $past(flag_sat)));

  a_r9_reg_form: assert property (@(posedge clk) disable iff (rst)
    (primed && cond_met && !$past(use_imm)) |-> (move_result == $past(reg_a)));

  a_r9_fail_path: assert property (@(posedge clk) disable iff (rst)
    (primed && !cond_met) |-> (move_result == $past(reg_b)));

  a_r10_imm_form: assert property (@(posedge clk) disable iff (rst)
    (primed && cond_met && $past(use_imm)) |->
      (move_result == {{(DATA_W-IMM_W){$past(imm5[IMM_W-1])}}, $past(imm5)}));

  a_r11_setf_value: assert property (@(posedge clk) disable iff (rst)
    primed |-> (setf_result == {{(DATA_W-1){1'b0}}, cond_met}));
endmodule

bind cond_move_unit cond_move_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .cond_code(cond_code), .flag_z(flag_z), .flag_s(flag_s),
  .flag_ov(flag_ov), .flag_cy(flag_cy), .flag_sat(flag_sat), .use_imm(use_imm),
  .imm5(imm5), .reg_a(reg_a), .reg_b(reg_b), .cond_met(cond_met),
  .move_result(move_result), .setf_result(setf_result)
);

// File: tb/sim_cond_move_unit.sv
`timescale 1ns/1ps
module sim_cond_move_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cond_code = 4'h0;
  logic        flag_z = 0, flag_s = 0, flag_ov = 0, flag_cy = 0, flag_sat = 0;
  logic        use_imm = 0;
  logic [4:0]  imm5 = 5'h0;
  logic [31:0] reg_a = 32'h0, reg_b = 32'h0;
  logic        cond_met;
  logic [31:0] move_result, setf_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic        cm;
    logic [31:0] mv;
    logic [31:0] sf;
    string       ctag;
    string       mtag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  cond_move_unit u0 (
    .clk(clk), .rst(rst), .cond_code(cond_code), .flag_z(flag_z), .flag_s(flag_s),
    .flag_ov(flag_ov), .flag_cy(flag_cy), .flag_sat(flag_sat), .use_imm(use_imm),
    .imm5(imm5), .reg_a(reg_a), .reg_b(reg_b), .cond_met(cond_met),
    .move_result(move_result), .setf_result(setf_result)
  );

  function automatic logic exp_met(input logic [3:0] c, input logic z, s, ov, cy, sat);
    case (c)
      4'h0: return ov;
      4'h8: return !ov;
      4'h1: return cy;
      4'h9: return !cy;
      4'h2: return z;
      4'hA: return !z;
      4'h4: return s;
      4'hC: return !s;
      4'h6: return s ^ ov;
      4'hE: return !(s ^ ov);
      4'h7: return (s ^ ov) | z;
      4'hF: return !((s ^ ov) | z);
      4'h3: return cy | z;
      4'hB: return !(cy | z);
      4'h5: return 1'b1;
      default: return sat;
    endcase
  endfunction

  function automatic string code_tag(input logic [3:0] c);
    case (c)
      4'h0, 4'h8: return "R2";
      4'h1, 4'h9: return "R3";
      4'h2, 4'hA: return "R4";
      4'h4, 4'hC: return "R5";
      4'h6, 4'hE, 4'h7, 4'hF: return "R6";
      4'h3, 4'hB: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one stimulus at the falling edge and queue its expected result.
  task automatic drive(input logic [3:0] c, input logic [4:0] fl, input logic ui,
                       input logic [4:0] im, input logic [31:0] a, input logic [31:0] b);
    item_t it;
    logic m;
    logic [31:0] first;
    @(negedge clk);
    cond_code = c;
    {flag_z, flag_s, flag_ov, flag_cy, flag_sat} = fl;
    use_imm = ui; imm5 = im; reg_a = a; reg_b = b;
    m = exp_met(c, fl[4], fl[3], fl[2], fl[1], fl[0]);
    first = ui ? {{27{im[4]}}, im} : a;
    it.cm = m;
    it.mv = m ? first : b;
    it.sf = m ? 32'd1 : 32'd0;
    it.ctag = code_tag(c);
    it.mtag = ui ? "R10" : "R9";
    sb.push_back(it);
  endtask

  // Monitor: one registered stage, so compare shortly after the next rising edge (R12).
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.ctag, "/R12 cond_met"}, {31'b0, cond_met}, {31'b0, it.cm});
        check({it.mtag, " move_result"}, move_result, it.mv);
        check("R11 setf_result", setf_result, it.sf);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state: drive inputs that would produce nonzero outputs.
    cond_code = 4'h5; reg_a = 32'hDEAD_BEEF; reg_b = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #2;
    check("R1 cond_met", {31'b0, cond_met}, 32'd0);
    check("R1 move_result", move_result, 32'd0);
    check("R1 setf_result", setf_result, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // Full sweep of codes against flag combinations, alternating operand forms.
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        drive(c[3:0], f[4:0], f[0] ^ c[0], 5'($urandom), $urandom, $urandom);
      end
    end

    // Sign-extension boundary of the immediate, condition forced true by code 0x5.
    drive(4'h5, 5'b00000, 1'b1, 5'h0F, 32'hAAAA_AAAA, 32'h5555_5555);
    drive(4'h5, 5'b00000, 1'b1, 5'h10, 32'hAAAA_AAAA, 32'h5555_5555);
    drive(4'h5, 5'b11111, 1'b1, 5'h1F, 32'h0, 32'h0);
    // Failing condition with immediate form must pass reg_b.
    drive(4'hD, 5'b11110, 1'b1, 5'h10, 32'h1111_1111, 32'h2222_2222);
    // Back-to-back toggling to probe one-cycle latency.
    drive(4'h2, 5'b10000, 1'b0, 5'h0, 32'hCAFE_0001, 32'hCAFE_0002);
    drive(4'h2, 5'b00000, 1'b0, 5'h0, 32'hCAFE_0003, 32'hCAFE_0004);
    drive(4'h2, 5'b10000, 1'b0, 5'h0, 32'hCAFE_0005, 32'hCAFE_0006);

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule